// File: doc/BRIEF.md
# Prefetching Read Streamer with Byte FIFO

The block pulls a contiguous range of memory into a local byte FIFO ahead of the consumer. Software or a controlling engine loads a base address and a byte count and pulses a start strobe. The block then issues read requests on its own request channel. Several requests may be outstanding at once. Each is tagged with the slot that will hold its returning data. Responses may come back in any order. The block buffers each one in its slot and moves data into the FIFO strictly in the order the requests were issued.

Before it issues a request, the block reserves FIFO space for every read still in flight. A burst of late responses can therefore never overrun the FIFO. The consumer asks for N bytes at a time, and the request succeeds only when N bytes are already buffered. A stop strobe ends the region at once. Reads already in flight still complete and release their slots, but their data is dropped. A drain input holds off new reads so the block can quiesce. Single-cycle indications mark the moment the region has been fully requested and the moment the block stops being busy.

Top module: `dpf_prefetch_fifo`

## Requirements
- R1: A request carries the current next address and a length equal to the smaller of MAX_REQ and the bytes left before the end address. After each accepted request, the next address advances by that length.
- R2: A request is offered only while a slot is free and the region is not fully requested. At most SLOTS requests are outstanding. Tags are handed out in rotating order 0,1,..,SLOTS-1, starting at 0 after reset.
- R3: A request is offered only if the buffered bytes, plus the bytes of all outstanding requests, plus the new length, do not exceed FIFO_BYTES.
- R4: Response data enters the FIFO in issue order whatever the response order. The earliest point is the cycle after the oldest request's response. `get_data` byte j (bits 8j+7:8j) is the j-th oldest buffered byte.
- R5: `get_ok` is high exactly when `get_len` is no larger than MAX_GET and at least `get_len` bytes are buffered. A `get_req` with `get_ok` high removes `get_len` bytes. A refused get changes nothing.
- R6: `fill_stop` makes the region fully requested at once and cancels every outstanding request. This includes one retiring in the same cycle. Canceled requests free their slots, but none of their data reaches the FIFO.
- R7: `fill_start` loads a new region only when the current region is fully requested and `fill_stop` is low. Otherwise it is ignored.
- R8: `at_eob` is high while the next address equals the end address. `eob_pulse` is high for one cycle when `at_eob` rises.
- R9: The block is busy while requests are outstanding or the region is not fully requested. `idle_pulse` is high for the one cycle in which busy has just fallen.
- R10: While `drain_req` is high, no request is offered. `drained` is high when `drain_req` is high and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_start | input | 1 | Load a new region |
| fill_stop | input | 1 | End the region and cancel reads in flight |
| fill_base | input | AW | Region start address |
| fill_bytes | input | AW | Region length in bytes |
| drain_req | input | 1 | Hold off new reads |
| drained | output | 1 | Drain requested and nothing outstanding |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_req_len | output | LENW | Read length in bytes |
| rd_req_tag | output | TAGW | Slot tag of the request |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_tag | input | TAGW | Slot tag of the response |
| rd_rsp_data | input | MAX_REQ*8 | Response bytes, byte 0 in bits 7:0 |
| get_req | input | 1 | Consumer takes bytes |
| get_len | input | GLW | Bytes requested |
| get_ok | output | 1 | Enough bytes buffered for get_len |
| get_data | output | MAX_GET*8 | Oldest buffered bytes |
| at_eob | output | 1 | Region fully requested |
| eob_pulse | output | 1 | Region has just become fully requested |
| idle_pulse | output | 1 | Block has just stopped being busy |

## Verification
A wrong slot pointer or a lost done flag shows up at `get_data` as misordered or missing bytes in the first get after the affected retirement. A stuck slot shows up as `rd_req_valid` staying low while the model expects a request. A miscounted reservation changes `rd_req_valid` in the very cycle the FIFO nears capacity. The bench therefore compares every output against a queue-based model on every clock. Responses are returned in forward and reverse order, with a request acceptor that stalls, so that ordering, reservation and cancellation errors become visible within a cycle or two.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

   // smaller of two lengths, used by the request sizing logic
   function automatic int unsigned dpf_min(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

   // true when v is a power of two and at least two
   function automatic bit dpf_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dpf_addr_gen.sv
module dpf_addr_gen #(
   parameter int AW         = 32,
   parameter int FIFO_BYTES = 32,
   parameter int MAX_REQ    = 8,
   localparam int LENW      = $clog2(MAX_REQ + 1),
   localparam int CNTW      = $clog2(FIFO_BYTES + 1),
   localparam int SW        = CNTW + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            stop,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   bytes,
   input  logic            drain,
   input  logic            slot_free,
   input  logic [CNTW-1:0] fifo_cnt,
   input  logic [CNTW-1:0] pend_bytes,
   input  logic            ready,
   output logic            valid,
   output logic            fire,
   output logic [AW-1:0]   addr,
   output logic [LENW-1:0] len,
   output logic            eob
);

   logic [AW-1:0] next_q, end_q, rem;
   logic          room;

   assign rem  = end_q - next_q;
   assign eob  = (next_q == end_q);
   assign len  = (rem >= AW'(MAX_REQ)) ? LENW'(MAX_REQ) : rem[LENW-1:0];
   assign addr = next_q;
   assign room = (SW'(fifo_cnt) + SW'(pend_bytes) + SW'(len)) <= SW'(FIFO_BYTES);
   assign valid = slot_free && !eob && !drain && !stop && room;
   assign fire  = valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= '0;
         end_q  <= '0;
      end else if (stop) begin
         next_q <= end_q;
      end else if (start && eob) begin
         next_q <= base;
         end_q  <= base + bytes;
      end else if (fire) begin
         next_q <= next_q + AW'(len);
      end
   end

endmodule

// File: rtl/dpf_slot_ring.sv
module dpf_slot_ring #(
   parameter int SLOTS      = 4,
   parameter int MAX_REQ    = 8,
   parameter int CNTW       = 6,
   localparam int TAGW      = $clog2(SLOTS),
   localparam int LENW      = $clog2(MAX_REQ + 1),
   localparam int DW        = MAX_REQ * 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc,
   input  logic [LENW-1:0] alloc_len,
   output logic [TAGW-1:0] alloc_tag,
   input  logic            rsp_valid,
   input  logic [TAGW-1:0] rsp_tag,
   input  logic [DW-1:0]   rsp_data,
   input  logic            cancel_all,
   output logic            slot_free,
   output logic [TAGW:0]   slot_cnt,
   output logic [CNTW-1:0] pend_bytes,
   output logic            ret_valid,
   output logic            ret_keep,
   output logic [LENW-1:0] ret_len,
   output logic [DW-1:0]   ret_data
);

   logic [TAGW-1:0]       head_q, tail_q;
   logic [TAGW:0]         cnt_q;
   logic [CNTW-1:0]       pend_q;
   logic [SLOTS*LENW-1:0] len_flat;
   logic [SLOTS*DW-1:0]   data_flat;
   logic [SLOTS-1:0]      done_vec, canc_vec;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [LENW-1:0] len_q;
      logic [DW-1:0]   data_q;
      logic            done_q, canc_q;
      logic            take, hit;

      assign take = alloc && (tail_q == TAGW'(g));
      assign hit  = rsp_valid && (rsp_tag == TAGW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_q  <= '0;
            done_q <= 1'b0;
            canc_q <= 1'b0;
         end else if (take) begin
            len_q  <= alloc_len;
            done_q <= 1'b0;
            canc_q <= 1'b0;
         end else begin
            if (hit)        done_q <= 1'b1;
            if (cancel_all) canc_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit) data_q <= rsp_data;
      end

      assign len_flat[g*LENW +: LENW] = len_q;
      assign data_flat[g*DW +: DW]    = data_q;
      assign done_vec[g]              = done_q;
      assign canc_vec[g]              = canc_q;
   end

   assign ret_valid  = (cnt_q != '0) && done_vec[head_q];
   assign ret_keep   = !canc_vec[head_q] && !cancel_all;
   assign ret_len    = len_flat[head_q*LENW +: LENW];
   assign ret_data   = data_flat[head_q*DW +: DW];
   assign slot_free  = (cnt_q < (TAGW+1)'(SLOTS));
   assign slot_cnt   = cnt_q;
   assign pend_bytes = pend_q;
   assign alloc_tag  = tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         pend_q <= '0;
      end else begin
         if (alloc)     tail_q <= tail_q + 1'b1;
         if (ret_valid) head_q <= head_q + 1'b1;
         case ({alloc, ret_valid})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         pend_q <= pend_q + (alloc ? CNTW'(alloc_len) : '0)
                          - (ret_valid ? CNTW'(ret_len) : '0);
      end
   end

endmodule

// File: rtl/dpf_byte_fifo.sv
module dpf_byte_fifo #(
   parameter int DEPTH      = 32,
   parameter int WR_MAX     = 8,
   parameter int RD_MAX     = 4,
   localparam int PTRW      = $clog2(DEPTH),
   localparam int CNTW      = $clog2(DEPTH + 1),
   localparam int WLW       = $clog2(WR_MAX + 1),
   localparam int RLW       = $clog2(RD_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WLW-1:0]    wr_len,
   input  logic [WR_MAX*8-1:0] wr_data,
   input  logic              rd_en,
   input  logic [RLW-1:0]    rd_len,
   output logic [CNTW-1:0]   count,
   output logic [RD_MAX*8-1:0] rd_data
);

   logic [7:0]      mem [DEPTH];
   logic [PTRW-1:0] wptr_q, rptr_q;
   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int i = 0; i < WR_MAX; i++) begin
            if (WLW'(i) < wr_len) mem[wptr_q + PTRW'(i)] <= wr_data[i*8 +: 8];
         end
      end
   end

   always_comb begin
      for (int j = 0; j < RD_MAX; j++) begin
         rd_data[j*8 +: 8] = mem[rptr_q + PTRW'(j)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) wptr_q <= wptr_q + PTRW'(wr_len);
         if (rd_en) rptr_q <= rptr_q + PTRW'(rd_len);
         cnt_q <= cnt_q + (wr_en ? CNTW'(wr_len) : '0) - (rd_en ? CNTW'(rd_len) : '0);
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/dpf_prefetch_fifo.sv
module dpf_prefetch_fifo
   import dpf_pkg::*;
#(
   parameter int AW         = 32,
   parameter int FIFO_BYTES = 32,
   parameter int MAX_REQ    = 8,
   parameter int SLOTS      = 4,
   parameter int MAX_GET    = 4,
   localparam int LENW      = $clog2(MAX_REQ + 1),
   localparam int TAGW      = $clog2(SLOTS),
   localparam int GLW       = $clog2(MAX_GET + 1),
   localparam int CNTW      = $clog2(FIFO_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_start,
   input  logic                 fill_stop,
   input  logic [AW-1:0]        fill_base,
   input  logic [AW-1:0]        fill_bytes,
   input  logic                 drain_req,
   output logic                 drained,
   output logic                 rd_req_valid,
   input  logic                 rd_req_ready,
   output logic [AW-1:0]        rd_req_addr,
   output logic [LENW-1:0]      rd_req_len,
   output logic [TAGW-1:0]      rd_req_tag,
   input  logic                 rd_rsp_valid,
   input  logic [TAGW-1:0]      rd_rsp_tag,
   input  logic [MAX_REQ*8-1:0] rd_rsp_data,
   input  logic                 get_req,
   input  logic [GLW-1:0]       get_len,
   output logic                 get_ok,
   output logic [MAX_GET*8-1:0] get_data,
   output logic                 at_eob,
   output logic                 eob_pulse,
   output logic                 idle_pulse
);

   // elaboration-time parameter checks
   if (!dpf_pow2(SLOTS)) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (!dpf_pow2(FIFO_BYTES)) begin : g_bad_depth
      $error("FIFO_BYTES must be a power of two, at least 2");
   end
   if (dpf_min(MAX_REQ, FIFO_BYTES) != MAX_REQ || MAX_REQ < 1) begin : g_bad_req
      $error("MAX_REQ must lie in 1..FIFO_BYTES");
   end
   if (dpf_min(MAX_GET, FIFO_BYTES) != MAX_GET || MAX_GET < 1) begin : g_bad_get
      $error("MAX_GET must lie in 1..FIFO_BYTES");
   end

   logic                 fire, slot_free, eob, active;
   logic [TAGW:0]        slot_cnt;
   logic [CNTW-1:0]      pend_bytes, fifo_cnt;
   logic                 ret_valid, ret_keep;
   logic [LENW-1:0]      ret_len;
   logic [MAX_REQ*8-1:0] ret_data;
   logic                 eob_prev_q, active_prev_q;

   dpf_addr_gen #(.AW(AW), .FIFO_BYTES(FIFO_BYTES), .MAX_REQ(MAX_REQ)) u_gen (
      .clk(clk), .rst_n(rst_n),
      .start(fill_start), .stop(fill_stop),
      .base(fill_base), .bytes(fill_bytes),
      .drain(drain_req), .slot_free(slot_free),
      .fifo_cnt(fifo_cnt), .pend_bytes(pend_bytes),
      .ready(rd_req_ready),
      .valid(rd_req_valid), .fire(fire),
      .addr(rd_req_addr), .len(rd_req_len), .eob(eob)
   );

   dpf_slot_ring #(.SLOTS(SLOTS), .MAX_REQ(MAX_REQ), .CNTW(CNTW)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .alloc(fire), .alloc_len(rd_req_len), .alloc_tag(rd_req_tag),
      .rsp_valid(rd_rsp_valid), .rsp_tag(rd_rsp_tag), .rsp_data(rd_rsp_data),
      .cancel_all(fill_stop),
      .slot_free(slot_free), .slot_cnt(slot_cnt), .pend_bytes(pend_bytes),
      .ret_valid(ret_valid), .ret_keep(ret_keep),
      .ret_len(ret_len), .ret_data(ret_data)
   );

   assign get_ok = (32'(get_len) <= MAX_GET) && (32'(fifo_cnt) >= 32'(get_len));

   dpf_byte_fifo #(.DEPTH(FIFO_BYTES), .WR_MAX(MAX_REQ), .RD_MAX(MAX_GET)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ret_valid && ret_keep), .wr_len(ret_len), .wr_data(ret_data),
      .rd_en(get_req && get_ok), .rd_len(get_len),
      .count(fifo_cnt), .rd_data(get_data)
   );

   assign active     = (slot_cnt != '0) || !eob;
   assign at_eob     = eob;
   assign eob_pulse  = eob && !eob_prev_q;
   assign idle_pulse = active_prev_q && !active;
   assign drained    = drain_req && (slot_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eob_prev_q    <= 1'b1;
         active_prev_q <= 1'b0;
      end else begin
         eob_prev_q    <= eob;
         active_prev_q <= active;
      end
   end

endmodule

// File: rtl/dpf_prefetch_fifo_chk.sv
module dpf_prefetch_fifo_chk #(
   parameter int FIFO_BYTES = 32,
   parameter int MAX_REQ    = 8,
   parameter int SLOTS      = 4,
   parameter int LENW       = 4,
   parameter int TAGW       = 2,
   parameter int CNTW       = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_req_valid,
   input logic [LENW-1:0] rd_req_len,
   input logic            drain_req,
   input logic            fill_stop,
   input logic            at_eob,
   input logic            eob_pulse,
   input logic            idle_pulse,
   input logic            get_req,
   input logic            get_ok,
   input logic [CNTW-1:0] fifo_cnt,
   input logic [CNTW-1:0] pend_bytes,
   input logic [TAGW:0]   slot_cnt,
   input logic            ret_valid
);

   assert_req_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rd_req_len != '0) && (32'(rd_req_len) <= MAX_REQ));

   assert_slot_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(slot_cnt) <= SLOTS);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(fifo_cnt) + 32'(pend_bytes)) <= FIFO_BYTES);

   assert_refused_get_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (get_req && !get_ok && !ret_valid) |=> (fifo_cnt == $past(fifo_cnt)));

   assert_stop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_stop |=> at_eob);

   assert_eob_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eob_pulse |=> !eob_pulse);

   assert_idle_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> (slot_cnt == '0) && at_eob);

   assert_drain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drain_req |-> !rd_req_valid);

endmodule

bind dpf_prefetch_fifo dpf_prefetch_fifo_chk #(
   .FIFO_BYTES(FIFO_BYTES), .MAX_REQ(MAX_REQ), .SLOTS(SLOTS),
   .LENW(LENW), .TAGW(TAGW), .CNTW(CNTW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rd_req_valid(rd_req_valid), .rd_req_len(rd_req_len),
   .drain_req(drain_req), .fill_stop(fill_stop),
   .at_eob(at_eob), .eob_pulse(eob_pulse), .idle_pulse(idle_pulse),
   .get_req(get_req), .get_ok(get_ok),
   .fifo_cnt(fifo_cnt), .pend_bytes(pend_bytes),
   .slot_cnt(slot_cnt), .ret_valid(ret_valid)
);

// File: tb/test_dpf_prefetch_fifo.sv
`timescale 1ns/1ps
module test_dpf_prefetch_fifo;

   localparam int AW = 32, CAP = 32, MR = 8, NS = 4, MG = 4;
   localparam int LENW = $clog2(MR + 1), TAGW = $clog2(NS), GLW = $clog2(MG + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            fill_start = 0, fill_stop = 0, drain_req = 0;
   logic [AW-1:0]   fill_base = '0, fill_bytes = '0;
   logic            drained, rd_req_valid, rd_req_ready = 1;
   logic [AW-1:0]   rd_req_addr;
   logic [LENW-1:0] rd_req_len;
   logic [TAGW-1:0] rd_req_tag;
   logic            rd_rsp_valid = 0;
   logic [TAGW-1:0] rd_rsp_tag = '0;
   logic [MR*8-1:0] rd_rsp_data = '0;
   logic            get_req = 0;
   logic [GLW-1:0]  get_len = '0;
   logic            get_ok;
   logic [MG*8-1:0] get_data;
   logic            at_eob, eob_pulse, idle_pulse;

   dpf_prefetch_fifo i_dpf_prefetch_fifo (
      .clk(clk), .rst_n(rst_n),
      .fill_start(fill_start), .fill_stop(fill_stop),
      .fill_base(fill_base), .fill_bytes(fill_bytes),
      .drain_req(drain_req), .drained(drained),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_req_tag(rd_req_tag),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_tag(rd_rsp_tag), .rd_rsp_data(rd_rsp_data),
      .get_req(get_req), .get_len(get_len), .get_ok(get_ok), .get_data(get_data),
      .at_eob(at_eob), .eob_pulse(eob_pulse), .idle_pulse(idle_pulse)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(int a);
      return 8'((a * 13 + 5) & 255);
   endfunction

   // behavioural reference model
   typedef struct { int tag; int addr; int len; bit done; bit canc; } pend_t;
   pend_t      pq[$];
   logic [7:0] fq[$];
   int m_next = 0, m_end = 0, ntag = 0, cyc = 0;
   bit eob_prev = 1, act_prev = 0;
   bit rsp_en = 0, rsp_rev = 0, cons_en = 0, rdy_toggle = 0;
   int cons_len = 4;

   task automatic step();
      bit eob, can, act, gok;
      int rem, rl, pb, k;
      // responder: oldest or youngest outstanding request without a response
      rd_rsp_valid = 0; rd_rsp_tag = '0; rd_rsp_data = '0;
      k = -1;
      if (rsp_en) begin
         for (int i = 0; i < pq.size(); i++)
            if (!pq[i].done && (k < 0 || rsp_rev)) k = i;
      end
      if (k >= 0) begin
         rd_rsp_valid = 1;
         rd_rsp_tag = TAGW'(pq[k].tag);
         for (int i = 0; i < pq[k].len; i++) rd_rsp_data[i*8 +: 8] = mb(pq[k].addr + i);
      end
      get_req = cons_en;
      get_len = GLW'(cons_len);
      rd_req_ready = rdy_toggle ? ((cyc % 3) != 0) : 1'b1;
      #1;
      eob = (m_next == m_end);
      rem = m_end - m_next;
      rl = (rem < MR) ? rem : MR;
      pb = 0;
      foreach (pq[i]) pb += pq[i].len;
      can = (pq.size() < NS) && !eob && !drain_req && !fill_stop && (fq.size() + pb + rl <= CAP);
      act = (pq.size() != 0) || !eob;
      gok = (cons_len <= MG) && (fq.size() >= cons_len);
      check("R2/R3/R6/R10 rd_req_valid", 64'(rd_req_valid), 64'(can));
      if (can) begin
         check("R1/R7 rd_req_addr", 64'(rd_req_addr), 64'(m_next));
         check("R1 rd_req_len", 64'(rd_req_len), 64'(rl));
         check("R2 rd_req_tag", 64'(rd_req_tag), 64'(ntag));
      end
      check("R5 get_ok", 64'(get_ok), 64'(gok));
      if (get_req && gok)
         for (int j = 0; j < cons_len; j++)
            check("R4/R6 get_data byte", 64'(get_data[j*8 +: 8]), 64'(fq[j]));
      check("R8 at_eob", 64'(at_eob), 64'(eob));
      check("R8 eob_pulse", 64'(eob_pulse), 64'(eob && !eob_prev));
      check("R9 idle_pulse", 64'(idle_pulse), 64'(act_prev && !act));
      check("R10 drained", 64'(drained), 64'(drain_req && pq.size() == 0));
      // state update at the coming edge
      if (get_req && gok) repeat (cons_len) void'(fq.pop_front());
      if (pq.size() != 0 && pq[0].done) begin
         if (!pq[0].canc && !fill_stop)
            for (int i = 0; i < pq[0].len; i++) fq.push_back(mb(pq[0].addr + i));
         void'(pq.pop_front());
      end
      if (can && rd_req_ready) begin
         pq.push_back('{ntag, m_next, rl, 1'b0, 1'b0});
         m_next += rl;
         ntag = (ntag + 1) % NS;
      end
      if (rd_rsp_valid)
         foreach (pq[i]) if (pq[i].tag == int'(rd_rsp_tag) && !pq[i].done) pq[i].done = 1;
      if (fill_stop) begin
         foreach (pq[i]) pq[i].canc = 1;
         m_next = m_end;
      end else if (fill_start && eob) begin
         m_next = int'(fill_base);
         m_end = int'(fill_base + fill_bytes);
      end
      eob_prev = eob;
      act_prev = act;
      @(negedge clk);
      cyc++;
      fill_start = 0;
      fill_stop = 0;
   endtask

   task automatic run(int n);
      repeat (n) step();
   endtask

   task automatic start_region(int base, int len);
      fill_base = AW'(base);
      fill_bytes = AW'(len);
      fill_start = 1;
      step();
   endtask

   task automatic empty_fifo();
      cons_en = 1;
      for (int n = 0; n < 200 && (fq.size() != 0 || pq.size() != 0); n++) begin
         cons_len = (fq.size() >= MG) ? MG : ((fq.size() == 0) ? 1 : fq.size());
         step();
      end
      cons_en = 0;
      cons_len = 4;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R1..all actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      get_len = 1;
      #1;
      check("R2 reset no request", 64'(rd_req_valid), 64'(0));
      check("R8 reset at_eob", 64'(at_eob), 64'(1));
      check("R5 reset get refused", 64'(get_ok), 64'(0));
      check("R9 reset no idle pulse", 64'(idle_pulse), 64'(0));
      @(negedge clk);

      // R3: region larger than the FIFO, in-order responses, no consumer
      rsp_en = 1;
      start_region('h100, 40);
      run(20);
      cons_en = 1; cons_len = 4;
      run(20);
      empty_fifo();
      run(2);

      // R4: short odd region, reversed responses, stalling acceptor
      rsp_rev = 1; rdy_toggle = 1;
      start_region('h203, 13);
      run(25);
      cons_en = 1; cons_len = 5;   // beyond MAX_GET: refused
      run(2);
      cons_len = 3;
      run(4);
      cons_len = 2;
      run(2);
      empty_fifo();
      rsp_rev = 0; rdy_toggle = 0;
      run(2);

      // R7: start while busy is ignored; R6: stop cancels reads in flight
      rsp_en = 0;
      start_region('h400, 64);
      run(3);
      start_region('h900, 8);
      run(3);
      fill_stop = 1;
      step();
      rsp_en = 1;
      run(10);
      cons_len = 1;
      run(2);
      start_region('h500, 8);
      run(8);
      empty_fifo();

      // R6: stop in the cycle the oldest read retires
      rsp_en = 1;
      start_region('h700, 24);
      run(2);
      fill_stop = 1;
      step();
      run(8);
      empty_fifo();

      // R10: drain holds off reads until responses settle
      rsp_en = 0;
      start_region('h600, 24);
      run(3);
      drain_req = 1;
      run(3);
      rsp_en = 1;
      run(8);
      drain_req = 0;
      run(12);
      empty_fifo();
      run(3);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule